// File: doc/BRIEF.md
# Dispatch-Group Store-to-Load Conflict Guard

This block sits beside an instruction scheduler that bundles operations into dispatch groups. Each store issued into the open group is written into a small table. The table keeps two operand tags, a flag saying whether the first operand is a constant offset, that offset, and the access size. Operand identity comes from tags supplied by the surrounding logic. The block never forms an effective address.

Each cycle a load candidate presents its own operands and size. The block decides at once, with no clock in the path, whether that load may touch bytes written by a store already recorded in the group. If it may, the block raises a request to insert a no-op instead of issuing the load.

The scheduler pulses a group-end input when a group closes. That pulse empties the table. A store offered while the table is already full is dropped, and a sticky overflow flag is set.

Top module: `stld_overlap_guard`

## Requirements
- R1: A valid load whose first and second operand tags both equal those of a recorded store, in the same order, raises `noopReq` in the same cycle.
- R2: A valid load whose first operand tag equals a recorded store's second tag, and whose second tag equals that store's first tag, raises `noopReq`.
- R3: When the second (base) tags are equal and both first operands are flagged constant, the block compares byte ranges using signed 16-bit offsets. If the store offset is lower, a conflict exists when store offset plus store bytes exceeds the load offset. Otherwise a conflict exists when load offset plus load bytes exceeds the store offset. When either first operand is not a constant, no range compare is made.
- R4: The size code is 3 bits: 0 means 1 byte, 1 means 2, 2 means 4, 3 means 8 and 4 means 16 bytes.
- R5: `noopReq` is high only while `loadValid` is high. It is low whenever no conflict exists.
- R6: A `groupEnd` pulse empties the table at the clock edge. With the table empty, no load raises `noopReq`.
- R7: The table holds 5 stores. A store offered while 5 are held, with no `groupEnd` in that cycle, is not recorded and sets `overflow` at the edge. `overflow` stays set until a `groupEnd` edge clears it.
- R8: A store offered in the same cycle as `groupEnd` is recorded as the first entry of the new group.
- R9: A store is captured at the clock edge. A load in that same cycle is judged only against stores recorded earlier, and the new store is visible from the next cycle.
- R10: While reset is held, and right after it, the table is empty, so `noopReq` is 0, and `overflow` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| storeValid | input | 1 | Store issue strobe; the store is captured at the edge |
| storeOpA | input | 8 | Store first operand tag (offset or index register) |
| storeOpB | input | 8 | Store second operand tag (base) |
| storeAConst | input | 1 | Store first operand is a constant offset |
| storeOffset | input | 16 | Store constant offset, signed |
| storeSize | input | 3 | Store size code (R4) |
| groupEnd | input | 1 | Dispatch group closes at this edge |
| loadValid | input | 1 | A load candidate is presented |
| loadOpA | input | 8 | Load first operand tag |
| loadOpB | input | 8 | Load second operand tag (base) |
| loadAConst | input | 1 | Load first operand is a constant offset |
| loadOffset | input | 16 | Load constant offset, signed |
| loadSize | input | 3 | Load size code (R4) |
| noopReq | output | 1 | Insert a no-op in place of the load (combinational) |
| overflow | output | 1 | Sticky flag: a store was dropped because the table was full |

## Verification
Directed loads tell the matching rules apart:
- An operand pair in the original order is compared with the same pair reversed, and with a pair where only the base agrees.
- One load shares the base but has a non-constant first operand, which shows that the range compare needs both constants.

Range cases place the load just inside and just outside the store's byte span, from both sides. They use negative offsets and the 16-byte size, so each off-by-one in the two compare directions would flip a result.

Sequencing patterns cover several other cases:
- a sixth store in a group;
- a store that arrives together with the group end;
- a load in the very cycle its store is captured.

A long random mix over a small tag space is then compared against a queue-based model on every cycle.

// File: rtl/stld_pkg.sv
package stld_pkg;

  localparam int unsigned TAG_W  = 8;
  localparam int unsigned OFF_W  = 16;
  localparam int unsigned SIZE_W = 3;
  localparam int unsigned EXT_W  = OFF_W + 2;

  // One memory access description, shared by stores and loads
  typedef struct packed {
    logic [TAG_W-1:0]  opA;
    logic [TAG_W-1:0]  opB;
    logic              aConst;
    logic [OFF_W-1:0]  offset;
    logic [SIZE_W-1:0] sizeCode;
  } accessReq_t;

  // Strobes from control to the table datapath
  typedef struct packed {
    logic wrEn;
    logic clearAll;
  } tblStrobe_t;

  function automatic logic [EXT_W-1:0] sizeBytes(input logic [SIZE_W-1:0] code);
    logic [EXT_W-1:0] b;
    case (code)
      3'd0:    b = EXT_W'(1);
      3'd1:    b = EXT_W'(2);
      3'd2:    b = EXT_W'(4);
      3'd3:    b = EXT_W'(8);
      default: b = EXT_W'(16);
    endcase
    return b;
  endfunction

endpackage

// File: rtl/stld_cmp.sv
module stld_cmp
  import stld_pkg::*;
(
  input  accessReq_t entry,
  input  accessReq_t load,
  output logic       hit
);

  logic exactHit, swapHit, baseEq, bothConst, rangeHit;
  logic signed [EXT_W-1:0] sOff, lOff, sEnd, lEnd;

  always_comb begin
    exactHit  = (entry.opA == load.opA) && (entry.opB == load.opB);
    swapHit   = (entry.opA == load.opB) && (entry.opB == load.opA);
    baseEq    = (entry.opB == load.opB);
    bothConst = entry.aConst && load.aConst;

    sOff = $signed({{2{entry.offset[OFF_W-1]}}, entry.offset});
    lOff = $signed({{2{load.offset[OFF_W-1]}}, load.offset});
    sEnd = sOff + $signed(sizeBytes(entry.sizeCode));
    lEnd = lOff + $signed(sizeBytes(load.sizeCode));

    if (sOff < lOff) rangeHit = (sEnd > lOff);
    else             rangeHit = (lEnd > sOff);

    hit = exactHit || swapHit || (baseEq && bothConst && rangeHit);
  end

endmodule

// File: rtl/stld_ctrl.sv
module stld_ctrl
  import stld_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             storeValid,
  input  logic             groupEnd,
  output tblStrobe_t       strobes,
  output logic [PTR_W-1:0] wrPtr,
  output logic             tableEmpty,
  output logic             overflow
);

  logic [CNT_W-1:0] count, countNext;
  logic             overflowNext;
  logic             tableFull;

  always_comb begin
    tableFull        = (count == CNT_W'(DEPTH));
    strobes.clearAll = groupEnd;
    strobes.wrEn     = storeValid && (groupEnd || !tableFull);
    wrPtr            = groupEnd ? '0 : PTR_W'(count);

    if (groupEnd)          countNext = storeValid ? CNT_W'(1) : '0;
    else if (strobes.wrEn) countNext = count + CNT_W'(1);
    else                   countNext = count;

    if (groupEnd)                    overflowNext = 1'b0;
    else if (storeValid && tableFull) overflowNext = 1'b1;
    else                             overflowNext = overflow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      count    <= countNext;
      overflow <= overflowNext;
    end
  end

  assign tableEmpty = (count == '0);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R7
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (groupEnd && !storeValid) |=> tableEmpty); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (storeValid && !groupEnd && tableFull) |=> (overflow && $stable(count))); // R7
  AST_OVF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    groupEnd |=> !overflow); // R7
  AST_END_WITH_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (groupEnd && storeValid) |=> (count == CNT_W'(1))); // R8

endmodule

// File: rtl/stld_table.sv
module stld_table
  import stld_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tblStrobe_t       strobes,
  input  logic [PTR_W-1:0] wrPtr,
  input  accessReq_t       storeReq,
  input  logic             loadValid,
  input  accessReq_t       loadReq,
  output logic             noopReq
);

  accessReq_t entryQ [DEPTH];
  logic [DEPTH-1:0] validQ;
  logic [DEPTH-1:0] cmpHit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobes.wrEn && (wrPtr == PTR_W'(i))) validQ[i] <= 1'b1;
        else if (strobes.clearAll)                validQ[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (strobes.wrEn && (wrPtr == PTR_W'(i))) entryQ[i] <= storeReq;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    stld_cmp uCmp (
      .entry (entryQ[g]),
      .load  (loadReq),
      .hit   (cmpHit[g])
    );
  end

  assign noopReq = loadValid && |(cmpHit & validQ);

  AST_NOOP_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    noopReq |-> loadValid); // R5
  AST_WRITE_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.wrEn |=> validQ[$past(wrPtr)]); // R9
  AST_CLEAR_ONLY_NEW: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.clearAll && !strobes.wrEn) |=> (validQ == '0)); // R6

endmodule

// File: rtl/stld_overlap_guard.sv
module stld_overlap_guard
  import stld_pkg::*;
#(
  parameter int unsigned DEPTH = 5,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              storeValid,
  input  logic [TAG_W-1:0]  storeOpA,
  input  logic [TAG_W-1:0]  storeOpB,
  input  logic              storeAConst,
  input  logic [OFF_W-1:0]  storeOffset,
  input  logic [SIZE_W-1:0] storeSize,
  input  logic              groupEnd,
  input  logic              loadValid,
  input  logic [TAG_W-1:0]  loadOpA,
  input  logic [TAG_W-1:0]  loadOpB,
  input  logic              loadAConst,
  input  logic [OFF_W-1:0]  loadOffset,
  input  logic [SIZE_W-1:0] loadSize,
  output logic              noopReq,
  output logic              overflow
);

  accessReq_t       storeReq, loadReq;
  tblStrobe_t       strobes;
  logic [PTR_W-1:0] wrPtr;
  logic             tableEmpty;

  assign storeReq = '{opA: storeOpA, opB: storeOpB, aConst: storeAConst,
                      offset: storeOffset, sizeCode: storeSize};
  assign loadReq  = '{opA: loadOpA, opB: loadOpB, aConst: loadAConst,
                      offset: loadOffset, sizeCode: loadSize};

  stld_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .storeValid (storeValid),
    .groupEnd   (groupEnd),
    .strobes    (strobes),
    .wrPtr      (wrPtr),
    .tableEmpty (tableEmpty),
    .overflow   (overflow)
  );

  stld_table #(.DEPTH(DEPTH)) uTable (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wrPtr     (wrPtr),
    .storeReq  (storeReq),
    .loadValid (loadValid),
    .loadReq   (loadReq),
    .noopReq   (noopReq)
  );

  AST_EMPTY_NO_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    tableEmpty |-> !noopReq); // R6

endmodule

// File: tb/tb_stld_overlap_guard.sv
module tb_stld_overlap_guard;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic storeValid = 0, storeAConst = 0, groupEnd = 0, loadValid = 0, loadAConst = 0;
  logic [7:0]  storeOpA = 0, storeOpB = 0, loadOpA = 0, loadOpB = 0;
  logic [15:0] storeOffset = 0, loadOffset = 0;
  logic [2:0]  storeSize = 0, loadSize = 0;
  logic noopReq, overflow;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  stld_overlap_guard dut (
    .clk(clk), .rst_n(rst_n),
    .storeValid(storeValid), .storeOpA(storeOpA), .storeOpB(storeOpB),
    .storeAConst(storeAConst), .storeOffset(storeOffset), .storeSize(storeSize),
    .groupEnd(groupEnd),
    .loadValid(loadValid), .loadOpA(loadOpA), .loadOpB(loadOpB),
    .loadAConst(loadAConst), .loadOffset(loadOffset), .loadSize(loadSize),
    .noopReq(noopReq), .overflow(overflow)
  );

  // Behavioural reference: a queue of recorded stores plus a sticky flag
  typedef struct {
    int a; int b; bit c; int off; int bytes;
  } rec_t;
  rec_t model[$];
  bit   modelOvf = 0;

  function automatic int toBytes(input logic [2:0] code);
    return (code > 3'd4) ? 16 : (1 << code);
  endfunction

  function automatic bit refNoop();
    int lo;
    int lb;
    if (!loadValid) return 0;
    lo = int'($signed(loadOffset));
    lb = toBytes(loadSize);
    foreach (model[i]) begin
      if (model[i].a == int'(loadOpA) && model[i].b == int'(loadOpB)) return 1;
      if (model[i].a == int'(loadOpB) && model[i].b == int'(loadOpA)) return 1;
      if (model[i].b == int'(loadOpB) && model[i].c && loadAConst) begin
        if (model[i].off < lo) begin
          if (model[i].off + model[i].bytes > lo) return 1;
        end else begin
          if (lo + lb > model[i].off) return 1;
        end
      end
    end
    return 0;
  endfunction

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Called just after a negedge with inputs set; checks, runs one edge, idles inputs
  task automatic tick(input string tag, input int expNoop = -1, input int expOvf = -1);
    rec_t r;
    #1;
    check(tag, noopReq, refNoop(), "noopReq vs model");
    check(tag, overflow, modelOvf, "overflow vs model");
    if (expNoop >= 0) check(tag, noopReq, expNoop[0], "noopReq vs directed");
    if (expOvf >= 0)  check(tag, overflow, expOvf[0], "overflow vs directed");
    @(posedge clk);
    if (groupEnd) begin
      model.delete();
      modelOvf = 0;
    end
    if (storeValid) begin
      if (model.size() < 5) begin
        r.a = int'(storeOpA); r.b = int'(storeOpB); r.c = storeAConst;
        r.off = int'($signed(storeOffset)); r.bytes = toBytes(storeSize);
        model.push_back(r);
      end else begin
        modelOvf = 1;
      end
    end
    @(negedge clk);
    storeValid = 0; groupEnd = 0; loadValid = 0;
  endtask

  task automatic st(input int a, input int b, input bit c, input int off, input int sz);
    storeValid = 1; storeOpA = 8'(a); storeOpB = 8'(b); storeAConst = c;
    storeOffset = 16'(off); storeSize = 3'(sz);
  endtask

  task automatic ld(input int a, input int b, input bit c, input int off, input int sz);
    loadValid = 1; loadOpA = 8'(a); loadOpB = 8'(b); loadAConst = c;
    loadOffset = 16'(off); loadSize = 3'(sz);
  endtask

  task automatic endGroup();
    groupEnd = 1;
    tick("R6_end");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    ld(1, 2, 1, 0, 0);
    #1;
    check("R10", noopReq, 0, "noopReq in reset");
    check("R10", overflow, 0, "overflow in reset");
    loadValid = 0;
    rst_n = 1;
    @(negedge clk);
    ld(1, 2, 0, 0, 0); tick("R10_R6_empty", 0, 0);

    // R1 / R2 exact and commuted operand pairs
    st(3, 7, 0, 0, 2); tick("R1_store");
    ld(3, 7, 0, 0, 2); tick("R1", 1);
    ld(3, 8, 0, 0, 2); tick("R1_nomatch", 0);
    ld(7, 3, 0, 0, 2); tick("R2", 1);
    ld(9, 7, 1, 0, 2); tick("R3_nonconst_store", 0);
    loadValid = 0; loadOpA = 3; loadOpB = 7; tick("R5", 0);
    endGroup();
    ld(3, 7, 0, 0, 2); tick("R6", 0);

    // R3 / R4 byte range overlap, base tag 5
    st(20, 5, 1, 8, 2); tick("R3_store");
    ld(21, 5, 1, 11, 0); tick("R3_inside_hi", 1);
    ld(21, 5, 1, 12, 0); tick("R3_abut_hi", 0);
    ld(21, 5, 1, 4, 3);  tick("R3_inside_lo", 1);
    ld(21, 5, 1, 0, 3);  tick("R3_abut_lo", 0);
    ld(21, 5, 0, 8, 2);  tick("R3_nonconst_load", 0);
    ld(21, 6, 1, 8, 2);  tick("R3_other_base", 0);
    endGroup();
    st(30, 5, 1, -4, 2); tick("R3_neg_store");
    ld(31, 5, 1, -1, 0); tick("R3_neg_in", 1);
    ld(31, 5, 1, 0, 0);  tick("R3_neg_out", 0);
    ld(31, 5, 1, -6, 1); tick("R3_neg_lo_out", 0);
    ld(31, 5, 1, -5, 1); tick("R3_neg_lo_in", 1);
    endGroup();
    st(40, 9, 1, 0, 4);  tick("R4_store16");
    ld(41, 9, 1, 15, 0); tick("R4_16_in", 1);
    ld(41, 9, 1, 16, 0); tick("R4_16_out", 0);
    ld(41, 9, 1, -16, 4); tick("R4_load16_out", 0);
    ld(41, 9, 1, -15, 4); tick("R4_load16_in", 1);
    endGroup();

    // R9 same-cycle store is not seen
    st(50, 51, 0, 0, 0); ld(50, 51, 0, 0, 0); tick("R9_same", 0);
    ld(50, 51, 0, 0, 0); tick("R9_next", 1);
    endGroup();

    // R7 overflow on sixth store
    for (int i = 0; i < 5; i++) begin
      st(60 + i, 70, 0, 0, 0); tick("R7_fill", -1, 0);
    end
    st(99, 98, 0, 0, 0); tick("R7_sixth", -1, 0);
    ld(99, 98, 0, 0, 0); tick("R7_dropped", 0, 1);
    ld(64, 70, 0, 0, 0); tick("R7_kept", 1, 1);
    // R8 store together with group end
    st(80, 81, 0, 0, 0); groupEnd = 1; tick("R8_end", -1, 1);
    ld(80, 81, 0, 0, 0); tick("R8", 1, 0);
    ld(64, 70, 0, 0, 0); tick("R8_old_gone", 0, 0);
    endGroup();

    // Random mix over a small tag space
    for (int n = 0; n < 400; n++) begin
      if ($urandom_range(99) < 40)
        st($urandom_range(3), $urandom_range(3), 1'($urandom_range(1)),
           $urandom_range(16) - 8, $urandom_range(4));
      if ($urandom_range(99) < 60)
        ld($urandom_range(3), $urandom_range(3), 1'($urandom_range(1)),
           $urandom_range(16) - 8, $urandom_range(4));
      groupEnd = ($urandom_range(99) < 12);
      tick("RND_R1_R3_R7");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule